// File: doc/BRIEF.md
# Four-Channel Periodic Interval Timer

This block holds four independent down-counting timers behind a small word-addressed register port. Software writes a reload value for each timer, then starts any subset of them with one write to a shared start register, in which each timer owns a 4-bit field. A running timer steps down once per tick of a common time base. The time base runs at a fixed rate, by default 1 MHz, produced by a prescaler from the system clock. When a timer's count has reached zero, the next tick reloads the count and emits a single-cycle interrupt pulse on that timer's own output, so the timer runs periodically with no further attention from software.

Software can read the current count of every timer at any time. Reload registers are write-only, and every offset that is not a count register reads as zero. The interrupt controller that collects the four pulses sits outside this block.

Top module: `quad_interval_timer`

## Requirements
- R1: While reset (rstN low) is held and directly after it, every count register reads 0, every timer is stopped and timerIrq is 0.
- R2: A write to word address i (0..3) stores busWdata as timer i's reload value. The write does not change the count, the running state or the interrupt output of any timer. The new value is used at the next start or reload.
- R3: A write to word address 8 starts every timer i whose field busWdata[4i+3:4i] is nonzero. On the next edge that timer's count becomes its reload value and the timer is running.
- R4: In a write to word address 8, a zero field leaves the corresponding timer exactly as it was, running or stopped, with its count untouched.
- R5: The prescaler produces one tick every CLK_HZ/TICK_HZ clock cycles, counting from reset release. The first tick falls on the (CLK_HZ/TICK_HZ)-th rising edge after rstN rises.
- R6: On a tick, a running timer whose count is nonzero decrements it. A running timer whose count is zero reloads it from the reload value and drives its timerIrq bit high for exactly the following cycle. timerIrq is 0 at all other times.
- R7: With busSel high and busWr low, busRdata shows the count of timer i when busAddr is 4+i. It shows 0 at every other address, including the reload and start addresses. busRdata is 0 when no read is selected.
- R8: When a start for a timer lands on the same edge as that timer's expiry tick, the start takes priority: the count is loaded from the reload value and no interrupt pulse is emitted for that edge.
- R9: Writes to the count addresses (4..7) or to any address from 9 upward change no timer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access valid this cycle |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| timerIrq | output | 4 | One-cycle expiry pulse per timer |

## Verification
The tricky overlap is a start write for a timer arriving on the very edge where its prescaler tick would expire it. The bench provokes this by tracking the tick phase and the timer's count in its own model, then issuing the start write in the cycle just before a tick while the count is zero. It judges the result by checking that no pulse appears on that timer's output in the next cycle and that its count reads back as the reload value. Random start and reload writes also fall on tick edges, and every cycle's interrupt vector is compared with the model.

// File: rtl/qit_pkg.sv
package qit_pkg;

  localparam int NUM_TMR   = 4;
  localparam int FIELD_W   = 4;
  localparam int DATA_W    = 32;
  localparam int LEN_BASE  = 0;
  localparam int VAL_BASE  = 4;
  localparam int CTRL_IDX  = 8;

  typedef struct packed {
    logic               tick;
    logic [NUM_TMR-1:0] lenWr;
    logic [NUM_TMR-1:0] start;
  } qit_strobe_t;

endpackage

// File: rtl/qit_ctrl.sv
module qit_ctrl
  import qit_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busSel,
  input  logic                            busWr,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWdata,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   counts,
  output logic [DATA_W-1:0]               busRdata,
  output qit_strobe_t                     strobe
);

  localparam int DIV   = CLK_HZ / TICK_HZ;
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_IDX);

  logic [PRE_W-1:0] preCnt;
  logic             tickNow;
  logic             wrEn;
  logic             rdEn;

  assign tickNow = (preCnt == PRE_LAST);
  assign wrEn    = busSel & busWr;
  assign rdEn    = busSel & ~busWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (tickNow) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  assign strobe.tick = tickNow;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] LEN_ADDR = ADDR_W'(LEN_BASE + i);
    assign strobe.lenWr[i] = wrEn && (busAddr == LEN_ADDR);
    assign strobe.start[i] = wrEn && (busAddr == CTRL_ADDR) &&
                             (busWdata[FIELD_W*i +: FIELD_W] != '0);
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (busAddr == ADDR_W'(VAL_BASE + i)) begin
          busRdata = DATA_W'(counts[i]);
        end
      end
    end
  end

endmodule

// File: rtl/qit_datapath.sv
module qit_datapath
  import qit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  qit_strobe_t                   strobe,
  input  logic [CNT_W-1:0]              wdata,
  output logic [NUM_TMR-1:0][CNT_W-1:0] counts,
  output logic [NUM_TMR-1:0][CNT_W-1:0] limits,
  output logic [NUM_TMR-1:0]            running,
  output logic [NUM_TMR-1:0]            irq
);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [CNT_W-1:0] limitQ;
    logic [CNT_W-1:0] cntQ;
    logic             runQ;
    logic             irqQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        limitQ <= '0;
        cntQ   <= '0;
        runQ   <= 1'b0;
        irqQ   <= 1'b0;
      end else begin
        irqQ <= 1'b0;
        if (strobe.lenWr[i]) begin
          limitQ <= wdata;
        end
        if (strobe.start[i]) begin
          cntQ <= limitQ;
          runQ <= 1'b1;
        end else if (runQ && strobe.tick) begin
          if (cntQ == '0) begin
            cntQ <= limitQ;
            irqQ <= 1'b1;
          end else begin
            cntQ <= cntQ - CNT_W'(1);
          end
        end
      end
    end

    assign counts[i]  = cntQ;
    assign limits[i]  = limitQ;
    assign running[i] = runQ;
    assign irq[i]     = irqQ;
  end

endmodule

// File: rtl/quad_interval_timer.sv
module quad_interval_timer
  import qit_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [3:0]        timerIrq
);

  qit_strobe_t                   strobe;
  logic [NUM_TMR-1:0][CNT_W-1:0] counts;
  logic [NUM_TMR-1:0][CNT_W-1:0] limits;
  logic [NUM_TMR-1:0]            running;

  qit_ctrl #(
    .CLK_HZ (CLK_HZ),
    .TICK_HZ(TICK_HZ),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .counts  (counts),
    .busRdata(busRdata),
    .strobe  (strobe)
  );

  qit_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (busWdata[CNT_W-1:0]),
    .counts (counts),
    .limits (limits),
    .running(running),
    .irq    (timerIrq)
  );

endmodule

// File: rtl/qit_checker.sv
module qit_checker
  import qit_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int CNT_W   = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input qit_strobe_t                   strobe,
  input logic [NUM_TMR-1:0][CNT_W-1:0] counts,
  input logic [NUM_TMR-1:0][CNT_W-1:0] limits,
  input logic [NUM_TMR-1:0]            running,
  input logic [3:0]                    timerIrq
);

  localparam int DIV = CLK_HZ / TICK_HZ;

  int gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= 0;
    end else if (strobe.tick) begin
      gapCnt <= 0;
    end else begin
      gapCnt <= gapCnt + 1;
    end
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |-> (gapCnt == DIV - 1));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      timerIrq[i] |=> !timerIrq[i]);

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      timerIrq[i] |-> ($past(strobe.tick) && $past(running[i]) &&
                       !$past(strobe.start[i])));

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.start[i] |=> (running[i] && counts[i] == $past(limits[i])));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!running[i] && !strobe.start[i]) |=> $stable(counts[i]));
  end

endmodule

bind quad_interval_timer qit_checker #(
  .CLK_HZ (CLK_HZ),
  .TICK_HZ(TICK_HZ),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .strobe  (strobe),
  .counts  (counts),
  .limits  (limits),
  .running (running),
  .timerIrq(timerIrq)
);

// File: tb/quad_interval_timer_tb.sv
module quad_interval_timer_tb;

  localparam int CLK_HZ  = 4_000_000;
  localparam int TICK_HZ = 1_000_000;
  localparam int DIV     = CLK_HZ / TICK_HZ;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  timerIrq;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  // model state
  logic [31:0] mLimit [4];
  logic [31:0] mCount [4];
  logic [3:0]  mRun;
  logic [3:0]  mIrq;
  int          mPre;

  always #4 clk = ~clk;

  quad_interval_timer #(
    .CLK_HZ (CLK_HZ),
    .TICK_HZ(TICK_HZ),
    .ADDR_W (4),
    .CNT_W  (32)
  ) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .timerIrq(timerIrq)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre <= 0;
      mRun <= '0;
      mIrq <= '0;
      for (int i = 0; i < 4; i++) begin
        mLimit[i] <= '0;
        mCount[i] <= '0;
      end
    end else begin
      mPre <= (mPre == DIV - 1) ? 0 : mPre + 1;
      for (int i = 0; i < 4; i++) begin
        mIrq[i] <= 1'b0;
        if (busSel && busWr && busAddr == 4'(i)) mLimit[i] <= busWdata;
        if (busSel && busWr && busAddr == 4'd8 && busWdata[4*i +: 4] != 4'd0) begin
          mCount[i] <= mLimit[i];
          mRun[i]   <= 1'b1;
        end else if (mRun[i] && mPre == DIV - 1) begin
          if (mCount[i] == 0) begin
            mCount[i] <= mLimit[i];
            mIrq[i]   <= 1'b1;
          end else begin
            mCount[i] <= mCount[i] - 1;
          end
        end
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [3:0] a);
    if (a >= 4'd4 && a <= 4'd7) return mCount[a - 4'd4];
    return 32'd0;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6: interrupt vector compared every cycle
  always @(negedge clk) begin
    if (rstN && cmpOn && !done)
      check(timerIrq == mIrq, "R6 irq vector", {28'd0, timerIrq}, {28'd0, mIrq});
  end

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input string req);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    check(busRdata == expRead(a), req, busRdata, expRead(a));
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    int period;
    bit hit;
    void'($urandom(32'd2024));

    // R1: state during reset
    repeat (3) @(negedge clk);
    for (int a = 4; a < 8; a++) begin
      busSel = 1'b1; busAddr = 4'(a); #1;
      check(busRdata == 32'd0, "R1 count in reset", busRdata, 32'd0);
    end
    check(timerIrq == 4'd0, "R1 irq in reset", {28'd0, timerIrq}, 32'd0);
    busSel = 1'b0;
    rstN = 1'b1;
    cmpOn = 1'b1;

    // R7: reload and start addresses read zero
    busRead(4'd0, "R7 length read");
    busRead(4'd8, "R7 ctrl read");
    busRead(4'd4, "R1 count after reset");

    // R2: reload writes leave counts untouched
    busWrite(4'd0, 32'd3);
    busWrite(4'd1, 32'd5);
    busWrite(4'd2, 32'd0);
    busWrite(4'd3, 32'd7);
    idle(10);
    for (int a = 4; a < 8; a++) busRead(4'(a), "R2 count unchanged");

    // R3: start timer 0 via field [3:0]
    busWrite(4'd8, 32'h0000_0001);
    busRead(4'd4, "R3 count loaded");
    // R4: other timers still stopped
    busRead(4'd5, "R4 timer1 idle");
    busRead(4'd7, "R4 timer3 idle");
    idle(40);
    busRead(4'd4, "R6 count running");

    // R3/R4: start timers 1..3, zero field for timer 0
    busWrite(4'd8, 32'h0000_2F80);
    for (int a = 4; a < 8; a++) busRead(4'(a), "R4 R3 mixed start");

    // R5: period of timer 2 (reload 0) and timer 1 (reload 5)
    @(negedge clk);
    while (!timerIrq[2]) @(negedge clk);
    t0 = 0;
    @(negedge clk);
    while (!timerIrq[2]) begin t0++; @(negedge clk); end
    period = t0 + 1;
    check(period == DIV, "R5 tick period", period, DIV);
    while (!timerIrq[1]) @(negedge clk);
    t0 = 0;
    @(negedge clk);
    while (!timerIrq[1]) begin t0++; @(negedge clk); end
    period = t0 + 1;
    check(period == 6 * DIV, "R5 R6 reload period", period, 6 * DIV);

    // R9: writes to count and undecoded addresses are ignored
    busWrite(4'd5, 32'hFFFF_FFFF);
    busWrite(4'd12, 32'hFFFF_FFFF);
    busWrite(4'd15, 32'h1234_5678);
    for (int a = 4; a < 8; a++) busRead(4'(a), "R9 count after ignored write");
    busRead(4'd12, "R7 undecoded read");

    // R8: start landing on the expiry tick of timer 0
    hit = 1'b0;
    for (int k = 0; k < 2000 && !hit; k++) begin
      @(negedge clk);
      if (mRun[0] && mCount[0] == 0 && mPre == DIV - 1) begin
        busSel = 1'b1; busWr = 1'b1; busAddr = 4'd8; busWdata = 32'h0000_0001;
        hit = 1'b1;
      end
    end
    check(hit, "R8 collision reached", {31'd0, hit}, 32'd1);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    check(timerIrq[0] == 1'b0, "R8 no pulse", {31'd0, timerIrq[0]}, 32'd0);
    busSel = 1'b1; busAddr = 4'd4; #1;
    check(busRdata == mLimit[0], "R8 count reloaded", busRdata, mLimit[0]);
    busSel = 1'b0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) begin
        busWrite(4'($urandom % 4), 32'($urandom % 10));
      end else if (op == 1) begin
        logic [31:0] d;
        d = '0;
        for (int i = 0; i < 4; i++)
          if ($urandom % 3 != 0) d[4*i +: 4] = 4'($urandom % 16);
        busWrite(4'd8, d);
      end else begin
        busRead(4'($urandom % 16), "R7 R3 random read");
      end
      idle($urandom % 12);
    end

    idle(20);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule